// File: doc/BRIEF.md
# Private Peripheral Region Decoder

This block sits at the front of a processor cluster's 4 KB private register window. It splits one synchronous slave port into several parts. The first is a small group of snoop-control registers, held inside the block. The second is the interrupt-controller CPU interfaces. The third is the timer/watchdog pairs. The last two live outside the block. They are reached through one-hot select lines, a sub-offset and a shared write strobe and write data.

Each kind of external target has two ways in. An alias window leads to the instance that belongs to the processor making the access, as given by the current-CPU input. The windows that follow it each name one instance explicitly, and the instance index is computed from the offset. An access that falls outside every defined location raises the error flag for one cycle. Such an access reads as zero and changes nothing. Read data is registered and appears on the cycle after the request.

Top module: `ppr_decoder`

## Requirements
- R1: After reset, rsp_err and rsp_rdata are zero, and the snoop control bit reads as 0.
- R2: A write to offset 0x000 stores only write-data bit 0. A later read of 0x000 returns that bit in bit 0, with every other bit zero.
- R3: Offset 0x004 reads the CPU count minus one in bits [1:0], with the other bits zero. Offset 0x008 reads the STAT_VAL parameter (default zero). Writes to either offset raise no error and change nothing.
- R4: A write to offset 0x00C raises no error and leaves the control bit unchanged. A read of 0x00C returns zero.
- R5: An access in 0x100–0x1FF raises gic_sel[cur_cpu] in the cycle of the request, with gic_off equal to address bits [7:0].
- R6: An access in 0x200–0x5FF raises gic_sel[(offset − 0x200) >> 8], with gic_off equal to address bits [7:0].
- R7: An access in 0x600–0x6FF raises tmr_sel[cur_cpu×2 + addr[5]], with tmr_off equal to address bits [3:0]. Here addr[5]=0 selects the timer and addr[5]=1 the watchdog.
- R8: An access in 0x700–0xAFF raises tmr_sel[((offset − 0x700) >> 8)×2 + addr[5]], with tmr_off equal to address bits [3:0].
- R9: Offsets 0xB00 and above, and snoop-group offsets other than 0x000, 0x004, 0x008 and 0x00C, are errors. An error raises rsp_err on the next cycle only, returns zero read data, asserts no select line and stores nothing.
- R10: The cycle after a read, rsp_rdata holds the value of the addressed location. For an external target, this is the gic_rdata or tmr_rdata presented during the request cycle. After a write or an idle cycle, rsp_rdata is zero.
- R11: Address bits above bit 11 have no effect on decoding.
- R12: At most one select line is high in any cycle, and none is high while req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits [11:0] decoded |
| req_wdata | input | DATA_W | Write data |
| cur_cpu | input | CPU_W | Index of the processor making the access |
| rsp_rdata | output | DATA_W | Registered read data |
| rsp_err | output | 1 | One-cycle error pulse for a bad access |
| tgt_write | output | 1 | Write strobe to external targets |
| tgt_wdata | output | DATA_W | Write data to external targets |
| gic_sel | output | NCPU | One-hot select of an interrupt CPU interface |
| gic_off | output | 8 | Register offset inside an interrupt CPU interface |
| gic_rdata | input | DATA_W | Read data from the selected interrupt CPU interface |
| tmr_sel | output | 2×NCPU | One-hot select of a timer or watchdog |
| tmr_off | output | 4 | Register offset inside a timer or watchdog |
| tmr_rdata | input | DATA_W | Read data from the selected timer or watchdog |

## Verification
The assertions assume that cur_cpu is below NCPU whenever the alias windows are used. They also assume that the external targets return read data combinationally in the cycle their select line is high. The bench keeps cur_cpu inside that range. It models each target as a pure function of its select line and offset. Seeded random addresses are drawn across every page of the window, with random upper bits. The snoop page is biased toward its four defined offsets. Directed accesses cover the window edges, the bad offsets and the idle cycles.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

   typedef enum logic [1:0] {
      RG_SCU = 2'd0,
      RG_GIC = 2'd1,
      RG_TMR = 2'd2,
      RG_BAD = 2'd3
   } region_e;

   localparam int unsigned WIN_W      = 12;
   localparam int unsigned PAGE_W     = 4;
   localparam int unsigned GIC_OFF_W  = 8;
   localparam int unsigned TMR_OFF_W  = 4;
   localparam int unsigned MAX_CPU    = 4;

   localparam logic [3:0] PG_SCU      = 4'h0;
   localparam logic [3:0] PG_GIC_OWN  = 4'h1;
   localparam logic [3:0] PG_GIC_BASE = 4'h2;
   localparam logic [3:0] PG_TMR_OWN  = 4'h6;
   localparam logic [3:0] PG_TMR_BASE = 4'h7;

   localparam logic [7:0] SCU_CTRL    = 8'h00;
   localparam logic [7:0] SCU_CFG     = 8'h04;
   localparam logic [7:0] SCU_STAT    = 8'h08;
   localparam logic [7:0] SCU_INVAL   = 8'h0C;

endpackage

// File: rtl/ppr_region_decode.sv
module ppr_region_decode
   import ppr_pkg::*;
#(
   parameter int unsigned NCPU  = 4,
   parameter int unsigned CPU_W = 2
) (
   input  logic [WIN_W-1:0] off,
   input  logic [CPU_W-1:0] cur_cpu,
   output region_e          rgn,
   output logic [CPU_W-1:0] idx,
   output logic             bad
);

   logic [PAGE_W-1:0] page;
   logic [PAGE_W-1:0] rel;
   logic              own_bad;

   assign page    = off[WIN_W-1:WIN_W-PAGE_W];
   assign own_bad = 32'(cur_cpu) >= NCPU;

   always_comb begin
      rgn = RG_BAD;
      idx = '0;
      bad = 1'b1;
      rel = '0;
      if (page == PG_SCU) begin
         rgn = RG_SCU;
         bad = !(off[7:0] inside {SCU_CTRL, SCU_CFG, SCU_STAT, SCU_INVAL});
      end else if (page == PG_GIC_OWN) begin
         rgn = RG_GIC;
         idx = cur_cpu;
         bad = own_bad;
      end else if (page < PG_TMR_OWN) begin
         rgn = RG_GIC;
         rel = page - PG_GIC_BASE;
         idx = rel[CPU_W-1:0];
         bad = 32'(rel) >= NCPU;
      end else if (page == PG_TMR_OWN) begin
         rgn = RG_TMR;
         idx = cur_cpu;
         bad = own_bad;
      end else if (page < PG_TMR_BASE + 4'(MAX_CPU)) begin
         rgn = RG_TMR;
         rel = page - PG_TMR_BASE;
         idx = rel[CPU_W-1:0];
         bad = 32'(rel) >= NCPU;
      end
      if (bad) rgn = RG_BAD;
   end

endmodule

// File: rtl/ppr_scu_regs.sv
module ppr_scu_regs
   import ppr_pkg::*;
#(
   parameter int unsigned NCPU     = 4,
   parameter int unsigned DATA_W   = 32,
   parameter logic [31:0] STAT_VAL = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        off,
   input  logic              wbit,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [DATA_W-1:0] CFG_WORD = DATA_W'(NCPU - 1);

   logic ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ctrl_q <= 1'b0;
      else if (wr_en && off == SCU_CTRL) ctrl_q <= wbit;
   end

   always_comb begin
      unique case (off)
         SCU_CTRL: rdata = DATA_W'(ctrl_q);
         SCU_CFG:  rdata = CFG_WORD;
         SCU_STAT: rdata = DATA_W'(STAT_VAL);
         default:  rdata = '0;
      endcase
   end

   // R2: the control bit moves only on a write to its own offset
   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && off == SCU_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/ppr_target_steer.sv
module ppr_target_steer
   import ppr_pkg::*;
#(
   parameter int unsigned NCPU  = 4,
   parameter int unsigned CPU_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  region_e           rgn,
   input  logic [CPU_W-1:0]  idx,
   input  logic              half,
   output logic [NCPU-1:0]   gic_sel,
   output logic [2*NCPU-1:0] tmr_sel
);

   logic go_gic;
   logic go_tmr;

   assign go_gic = valid && rgn == RG_GIC;
   assign go_tmr = valid && rgn == RG_TMR;

   for (genvar i = 0; i < NCPU; i++) begin : g_cpu
      assign gic_sel[i] = go_gic && idx == CPU_W'(i);
      for (genvar b = 0; b < 2; b++) begin : g_half
         assign tmr_sel[2*i+b] = go_tmr && idx == CPU_W'(i) && half == 1'(b);
      end
   end

   // R12: at most one target selected
   assert_sel_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gic_sel, tmr_sel}));

   // R12: no select while idle
   assert_sel_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> ({gic_sel, tmr_sel} == '0));

endmodule

// File: rtl/ppr_decoder.sv
module ppr_decoder
   import ppr_pkg::*;
#(
   parameter int unsigned NCPU     = 4,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter logic [31:0] STAT_VAL = 32'h0,
   localparam int unsigned CPU_W   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CPU_W-1:0]  cur_cpu,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              tgt_write,
   output logic [DATA_W-1:0] tgt_wdata,
   output logic [NCPU-1:0]   gic_sel,
   output logic [GIC_OFF_W-1:0] gic_off,
   input  logic [DATA_W-1:0] gic_rdata,
   output logic [2*NCPU-1:0] tmr_sel,
   output logic [TMR_OFF_W-1:0] tmr_off,
   input  logic [DATA_W-1:0] tmr_rdata
);

   if (NCPU < 1 || NCPU > MAX_CPU) begin : g_bad_ncpu
      $error("ppr_decoder: NCPU must be 1..4");
   end
   if (ADDR_W < WIN_W) begin : g_bad_addr
      $error("ppr_decoder: ADDR_W must cover the 4 KB window");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("ppr_decoder: DATA_W must be at least 8");
   end

   logic [WIN_W-1:0]  off;
   region_e           rgn;
   logic [CPU_W-1:0]  idx;
   logic              dec_bad;
   logic [DATA_W-1:0] scu_rd;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   logic              err_q;
   logic              unused_bits;

   assign off         = req_addr[WIN_W-1:0];
   assign unused_bits = ^req_addr[ADDR_W-1:WIN_W-1];

   ppr_region_decode #(.NCPU(NCPU), .CPU_W(CPU_W)) u_dec (
      .off     (off),
      .cur_cpu (cur_cpu),
      .rgn     (rgn),
      .idx     (idx),
      .bad     (dec_bad)
   );

   ppr_scu_regs #(.NCPU(NCPU), .DATA_W(DATA_W), .STAT_VAL(STAT_VAL)) u_scu (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (req_valid && req_write && rgn == RG_SCU),
      .off   (off[7:0]),
      .wbit  (req_wdata[0]),
      .rdata (scu_rd)
   );

   ppr_target_steer #(.NCPU(NCPU), .CPU_W(CPU_W)) u_steer (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (req_valid),
      .rgn     (rgn),
      .idx     (idx),
      .half    (off[5]),
      .gic_sel (gic_sel),
      .tmr_sel (tmr_sel)
   );

   assign gic_off   = off[GIC_OFF_W-1:0];
   assign tmr_off   = off[TMR_OFF_W-1:0];
   assign tgt_write = req_write;
   assign tgt_wdata = req_wdata;

   always_comb begin
      unique case (rgn)
         RG_SCU:  rd_mux = scu_rd;
         RG_GIC:  rd_mux = gic_rdata;
         RG_TMR:  rd_mux = tmr_rdata;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q   <= req_valid && dec_bad;
         rdata_q <= (req_valid && !req_write && !dec_bad) ? rd_mux : '0;
      end
   end

   assign rsp_rdata = rdata_q;
   assign rsp_err   = err_q;

   // R9: a bad access is flagged on the next cycle
   assert_err_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && dec_bad) |=> rsp_err);

   // R9: an error never carries data
   assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_rdata == '0);

   // R5: a selected interrupt interface is never followed by an error
   assert_gic_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|gic_sel) |=> !rsp_err);

   // R7: a selected timer is never followed by an error
   assert_tmr_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|tmr_sel) |=> !rsp_err);

endmodule

// File: tb/ppr_decoder_tb.sv
`timescale 1ns/1ps
module ppr_decoder_tb;

   localparam int NCPU = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [1:0]  cur_cpu = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic        tgt_write;
   logic [31:0] tgt_wdata;
   logic [3:0]  gic_sel;
   logic [7:0]  gic_off;
   logic [31:0] gic_rdata;
   logic [7:0]  tmr_sel;
   logic [3:0]  tmr_off;
   logic [31:0] tmr_rdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit ctrl_m = 1'b0;

   always #4 clk = ~clk;

   ppr_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .cur_cpu(cur_cpu),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .tgt_write(tgt_write),
      .tgt_wdata(tgt_wdata), .gic_sel(gic_sel), .gic_off(gic_off),
      .gic_rdata(gic_rdata), .tmr_sel(tmr_sel), .tmr_off(tmr_off),
      .tmr_rdata(tmr_rdata)
   );

   // target models: data is a function of the select line and offset
   always_comb begin
      gic_rdata = 32'h5555_5555;
      for (int i = 0; i < NCPU; i++)
         if (gic_sel[i]) gic_rdata = 32'hC100_0000 | (32'(i) << 8) | 32'(gic_off);
   end
   always_comb begin
      tmr_rdata = 32'hAAAA_AAAA;
      for (int i = 0; i < 2*NCPU; i++)
         if (tmr_sel[i]) tmr_rdata = 32'h7E00_0000 | (32'(i) << 4) | 32'(tmr_off);
   end

   task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // kind: 0 snoop, 1 interrupt iface, 2 timer, 3 bad
   task automatic predict(input logic [11:0] o, input int cpu,
                          output int kind, output int idx, output string rq);
      int pg = int'(o[11:8]);
      idx = 0;
      if (pg == 0) begin
         kind = (o[7:0] inside {8'h00, 8'h04, 8'h08, 8'h0C}) ? 0 : 3;
         rq = (kind == 3) ? "R9" : (o[7:0] == 8'h00) ? "R2" :
              (o[7:0] == 8'h0C) ? "R4" : "R3";
      end else if (pg == 1) begin kind = 1; idx = cpu; rq = "R5"; end
      else if (pg <= 5)     begin kind = 1; idx = pg - 2; rq = "R6"; end
      else if (pg == 6)     begin kind = 2; idx = cpu; rq = "R7"; end
      else if (pg <= 10)    begin kind = 2; idx = pg - 7; rq = "R8"; end
      else                  begin kind = 3; rq = "R9"; end
   endtask

   task automatic access(bit wr, logic [31:0] addr, logic [31:0] wd, int cpu, string tag);
      int kind, idx;
      string rq;
      logic [3:0]  eg;
      logic [7:0]  et;
      logic [31:0] erd;
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
      cur_cpu = 2'(cpu);
      #1;
      predict(addr[11:0], cpu, kind, idx, rq);
      if (tag != "") rq = tag;
      eg = '0; et = '0; erd = '0;
      if (kind == 1) begin
         eg = 4'(1 << idx);
         erd = 32'hC100_0000 | (32'(idx) << 8) | 32'(addr[7:0]);
      end else if (kind == 2) begin
         et = 8'(1 << (idx*2 + int'(addr[5])));
         erd = 32'h7E00_0000 | (32'(idx*2 + int'(addr[5])) << 4) | 32'(addr[3:0]);
      end else if (kind == 0) begin
         case (addr[7:0])
            8'h00:   erd = 32'(ctrl_m);
            8'h04:   erd = 32'(NCPU - 1);
            default: erd = '0;
         endcase
      end
      if (wr) erd = '0;
      chk(rq, "select", {gic_sel, tmr_sel}, {eg, et});
      if (kind == 1) chk(rq, "gic_off", gic_off, addr[7:0]);
      if (kind == 2) chk(rq, "tmr_off", tmr_off, addr[3:0]);
      if (wr && kind == 0 && addr[7:0] == 8'h00) ctrl_m = wd[0];
      @(negedge clk);
      chk((kind == 3) ? "R9" : rq, "rsp_err", rsp_err, (kind == 3));
      chk((kind == 1 || kind == 2) ? "R10" : rq, "rsp_rdata", rsp_rdata, erd);
      req_valid = 1'b0;
   endtask

   task automatic idle_check();
      req_valid = 1'b0;
      #1;
      chk("R12", "idle select", {gic_sel, tmr_sel}, '0);
      @(negedge clk);
      chk("R10", "idle rdata", rsp_rdata, '0);
      chk("R9", "idle err", rsp_err, 1'b0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset err", rsp_err, 1'b0);
      chk("R1", "reset rdata", rsp_rdata, '0);
      access(0, 32'h0000_0000, 0, 0, "R1");

      // snoop group
      access(1, 32'h0000_0000, 32'hFFFF_FFFF, 1, "R2");
      access(0, 32'h0000_0000, 0, 1, "R2");
      access(1, 32'h0000_0000, 32'hFFFF_FFFE, 2, "R2");
      access(0, 32'h0000_0000, 0, 2, "R2");
      access(1, 32'h0000_0000, 32'h1, 0, "R2");
      access(1, 32'h0000_0004, 32'h0, 0, "R3");
      access(0, 32'h0000_0004, 0, 0, "R3");
      access(1, 32'h0000_0008, 32'h3, 0, "R3");
      access(0, 32'h0000_0008, 0, 0, "R3");
      access(1, 32'h0000_000C, 32'h0, 3, "R4");
      access(0, 32'h0000_000C, 0, 3, "R4");
      access(0, 32'h0000_0000, 0, 3, "R4");
      access(1, 32'h0000_0010, 32'h0, 0, "R9");
      access(1, 32'h0000_0001, 32'h0, 0, "R9");
      access(0, 32'h0000_0000, 0, 0, "R9");

      // window edges
      access(0, 32'h0000_0100, 0, 3, "R5");
      access(0, 32'h0000_01FF, 0, 2, "R5");
      access(0, 32'h0000_0200, 0, 1, "R6");
      access(0, 32'h0000_05FC, 0, 1, "R6");
      access(0, 32'h0000_0600, 0, 2, "R7");
      access(1, 32'h0000_06A4, 32'h1234, 1, "R7");
      access(0, 32'h0000_0700, 0, 0, "R8");
      access(0, 32'h0000_0AEF, 0, 0, "R8");
      access(0, 32'h0000_0B00, 0, 0, "R9");
      access(1, 32'h0000_0FFC, 32'h1, 0, "R9");
      access(0, 32'hFFFF_F824, 0, 0, "R11");
      access(0, 32'h1234_5304, 0, 3, "R11");
      access(1, 32'hABCD_E000, 32'h0, 0, "R11");
      access(0, 32'h0000_0000, 0, 0, "R11");
      idle_check();
      idle_check();

      // seeded random mix
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a = $urandom;
         bit w = $urandom_range(0, 1) == 1;
         if (a[11:8] == 4'h0 && $urandom_range(0, 3) != 0)
            a[7:0] = 8'($urandom_range(0, 3) * 4);
         access(w, a, $urandom, $urandom_range(0, NCPU - 1), "");
         if ($urandom_range(0, 9) == 0) idle_check();
      end
      finish_run();
   end

endmodule